// File: doc/BRIEF.md
# Latched hex seven-segment decoder

This block turns a 4-bit binary code into the seven segment drives of one display digit. It covers the numerals 0 to 9 and the letters A to F, the letters drawn in a mix of upper- and lower-case shapes. The code first passes through a hold stage with an active-low load control. While the load is low, the stage takes a new code on every rising clock edge. While the load is high, it keeps the last code it took, so the data bus can serve other digits.

Several of these decoders can be chained to suppress zeros in a multidigit number. Each digit has an active-low zero-blank input and an active-low zero-blank output. A digit blanks itself only when its zero-blank input is low and its held code is zero. In that case it also drives its zero-blank output low, so the next digit down the chain may blank its own zero. A separate active-low force-blank input darkens the digit whatever the held code or the chain state. It stands in for the case where the blanking terminal is driven from outside.

Top module: `seg7_latched_decoder`

## Requirements
- R1: While reset is asserted, and after it is released but before any load, the held code is 0. With zero_blank_in_n and force_blank_n both high, seg_n reads 7'b0000001 and zero_blank_out_n reads 1.
- R2: On every rising clock edge with load_n low, code_in is captured. From that edge on, the outputs show the decode of the captured value.
- R3: On a rising edge with load_n high, the held code keeps its value, and changes on code_in have no effect on seg_n.
- R4: seg_n[6] drives segment a, seg_n[5] drives b, and so on down to seg_n[0], which drives g. A lit segment is driven 0. The lit pattern (abcdefg, 1 = lit) for each code is:
  - 0: 1111110
  - 1: 0110000
  - 2: 1101101
  - 3: 1111001
  - 4: 0110011
  - 5: 1011011
  - 6: 1011111
  - 7: 1110000
  - 8: 1111111
  - 9: 1111011
  - A: 1110111
  - b: 0011111
  - C: 1001110
  - d: 0111101
  - E: 1001111
  - F: 1000111
- R5: When zero_blank_in_n is low and the held code is 0, all seven seg_n bits are 1 and zero_blank_out_n is 0.
- R6: When zero_blank_in_n is low and the held code is not 0, the digit shows its normal glyph and zero_blank_out_n is 1.
- R7: When zero_blank_in_n is high, a held code of 0 shows the glyph 0 and zero_blank_out_n is 1.
- R8: When force_blank_n is low, all seven seg_n bits are 1, whatever the held code and zero_blank_in_n are. zero_blank_out_n still follows the rules of R5 to R7.
- R9: A load that happens while force_blank_n is low still updates the held code. Once force_blank_n returns high, the captured value is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_n | input | 1 | Active-low load; the code is captured on each edge while low |
| code_in | input | 4 | Binary code to display |
| zero_blank_in_n | input | 1 | Active-low ripple zero-blank input |
| force_blank_n | input | 1 | Active-low forced blank, overrides everything |
| seg_n | output | 7 | Active-low segment drives, bit 6 = a down to bit 0 = g |
| zero_blank_out_n | output | 1 | Active-low ripple zero-blank output |

## Verification
Forced blanking and ripple zero blanking can both apply in the same cycle. The bench provokes this by holding code 0 with zero_blank_in_n low while force_blank_n is also low. It expects a dark digit, with zero_blank_out_n still low, because the ripple decision does not depend on the force. A load under forced blank is also overlapped with a release of the force. The bench then checks that the digit comes back showing the newly captured code and not the old one.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;
  localparam seg_t SEG_ALL_OFF_N = '1;
endpackage

// File: rtl/seg7_reset_sync.sv
module seg7_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/seg7_code_hold.sv
module seg7_code_hold
  import seg7_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_n,
  input  code_t code_in,
  output code_t held
);
  code_t held_d;
  logic  load_en;

  always_comb begin
    load_en = ~load_n;
    held_d  = held;
    if (load_en) held_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held_d;
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> held == $past(code_in));

  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(held));
endmodule

// File: rtl/seg7_glyph_decode.sv
module seg7_glyph_decode
  import seg7_pkg::*;
(
  input  code_t code,
  output seg_t  lit
);
  always_comb begin
    unique case (code)
      4'h0: lit = 7'b1111110;
      4'h1: lit = 7'b0110000;
      4'h2: lit = 7'b1101101;
      4'h3: lit = 7'b1111001;
      4'h4: lit = 7'b0110011;
      4'h5: lit = 7'b1011011;
      4'h6: lit = 7'b1011111;
      4'h7: lit = 7'b1110000;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1111011;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b0011111;
      4'hC: lit = 7'b1001110;
      4'hD: lit = 7'b0111101;
      4'hE: lit = 7'b1001111;
      default: lit = 7'b1000111;
    endcase
  end
endmodule

// File: rtl/seg7_blank_ctrl.sv
module seg7_blank_ctrl
  import seg7_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t held,
  input  seg_t  lit,
  input  logic  zb_in_n,
  input  logic  force_n,
  output seg_t  seg_n,
  output logic  zb_out_n
);
  logic held_zero;
  logic ripple_hit;
  logic dark;

  always_comb begin
    held_zero  = (held == '0);
    ripple_hit = held_zero & ~zb_in_n;
    dark       = ripple_hit | ~force_n;
    seg_n      = dark ? SEG_ALL_OFF_N : ~lit;
    zb_out_n   = ~ripple_hit;
  end

  // R8
  force_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !force_n |-> seg_n == SEG_ALL_OFF_N);

  // R5
  zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zb_in_n && held == '0) |-> (seg_n == SEG_ALL_OFF_N && !zb_out_n));

  // R6
  nonzero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held != '0) |-> zb_out_n);

  // R7
  zero_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zb_in_n && force_n) |-> ($countones(~seg_n) >= 2 && zb_out_n));
endmodule

// File: rtl/seg7_latched_decoder.sv
module seg7_latched_decoder
  import seg7_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic [3:0] code_in,
  input  logic       zero_blank_in_n,
  input  logic       force_blank_n,
  output logic [6:0] seg_n,
  output logic       zero_blank_out_n
);
  logic  srst_n;
  code_t held;
  seg_t  lit;

  seg7_reset_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  seg7_code_hold hold_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .load_n  (load_n),
    .code_in (code_in),
    .held    (held)
  );

  seg7_glyph_decode dec_i (
    .code (held),
    .lit  (lit)
  );

  seg7_blank_ctrl blank_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .held     (held),
    .lit      (lit),
    .zb_in_n  (zero_blank_in_n),
    .force_n  (force_blank_n),
    .seg_n    (seg_n),
    .zb_out_n (zero_blank_out_n)
  );

  // R4
  full_eight_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (held == 4'h8 && force_blank_n) |-> seg_n == 7'b0000000);
endmodule

// File: tb/seg7_latched_decoder_tb_top.sv
module seg7_latched_decoder_tb_top;
  logic       clk;
  logic       rst_n;
  logic       load_n;
  logic [3:0] code_in;
  logic       zero_blank_in_n;
  logic       force_blank_n;
  logic [6:0] seg_n;
  logic       zero_blank_out_n;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_held;

  typedef struct {
    logic [6:0] seg;
    logic       zbo;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  seg7_latched_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .code_in(code_in),
    .zero_blank_in_n(zero_blank_in_n), .force_blank_n(force_blank_n),
    .seg_n(seg_n), .zero_blank_out_n(zero_blank_out_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] glyph(input logic [3:0] c);
    case (c)
      4'h0: return 7'b1111110;
      4'h1: return 7'b0110000;
      4'h2: return 7'b1101101;
      4'h3: return 7'b1111001;
      4'h4: return 7'b0110011;
      4'h5: return 7'b1011011;
      4'h6: return 7'b1011111;
      4'h7: return 7'b1110000;
      4'h8: return 7'b1111111;
      4'h9: return 7'b1111011;
      4'hA: return 7'b1110111;
      4'hB: return 7'b0011111;
      4'hC: return 7'b1001110;
      4'hD: return 7'b0111101;
      4'hE: return 7'b1001111;
      default: return 7'b1000111;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [6:0] es, input logic eb);
    checks++;
    if (seg_n !== es || zero_blank_out_n !== eb) begin
      errors++;
      $display("FAIL %s: seg_n=%b zbo=%b expected seg_n=%b zbo=%b",
               tag, seg_n, zero_blank_out_n, es, eb);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic ld_n, input logic zbi_n,
                       input logic fb_n, input string tag);
    exp_t e;
    logic ripple;
    @(negedge clk);
    code_in = c; load_n = ld_n; zero_blank_in_n = zbi_n; force_blank_n = fb_n;
    if (!ld_n) model_held = c;
    ripple = (model_held == 4'h0) && !zbi_n;
    e.seg = (ripple || !fb_n) ? 7'b1111111 : ~glyph(model_held);
    e.zbo = !ripple;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        compare(e.tag, e.seg, e.zbo);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; code_in = 4'h6;
    zero_blank_in_n = 1'b1; force_blank_n = 1'b1; model_held = 4'h0;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 7'b0000001, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after release", 7'b0000001, 1'b1);
    for (int i = 0; i < 16; i++) drive(4'(i), 1'b0, 1'b1, 1'b1, "R4 R2 glyph");
    drive(4'h5, 1'b0, 1'b1, 1'b1, "R2 load 5");
    drive(4'h9, 1'b1, 1'b1, 1'b1, "R3 hold vs 9");
    drive(4'h3, 1'b1, 1'b1, 1'b1, "R3 hold vs 3");
    drive(4'h0, 1'b1, 0, 1'b1, "R6 nonzero with zbi low");
    drive(4'h0, 1'b0, 0, 1'b1, "R5 zero blank");
    drive(4'h0, 1'b1, 0, 1'b1, "R5 zero blank held");
    drive(4'h0, 1'b1, 1'b1, 1'b1, "R7 zero shown");
    drive(4'hA, 1'b0, 0, 1'b1, "R6 letter A with zbi low");
    drive(4'h8, 1'b0, 1'b1, 0, "R8 force over 8");
    drive(4'h0, 1'b0, 0, 0, "R8 force and ripple together");
    drive(4'h0, 1'b1, 1'b1, 0, "R8 force zero, zbi high");
    drive(4'h7, 1'b0, 1'b1, 0, "R9 load under force");
    drive(4'h2, 1'b1, 1'b1, 1'b1, "R9 release shows 7");
    drive(4'hF, 1'b0, 0, 1'b1, "R6 F with zbi low");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule